// File: doc/BRIEF.md
# Exception Latch and Fault Status Generator

This block is the exception-control slice of a microcoded 16-bit processor. It holds the pending-trap vector, which is loaded at the start of an instruction's last microcycle with the next group 1 exception. It flags misaligned word and long accesses and takes an external bus-fault input. For each bus or address error it builds the fault status word that the fault stack frame stores.

The pending-trap vector is loaded before the current instruction has finished. The status word is built a few clocks after the fault is detected. A fault raised by the final bus cycle of an instruction can therefore report "not in an instruction". This happens when the following opcode is illegal or when a trace or an interrupt is waiting. Instruction sequencing, the microcode store and the writes that build the stack frame belong to other blocks.

All pins are plain control and status strobes. The block has no streaming interface, so there is no valid/ready pair and no back-pressure. Each fault is reported once, by a one-clock `fault_start` pulse. The block then assumes that the sequencer is stacking the frame until it raises `frame_done`.

Top module: `exc_status_gen`

## Requirements
- R1: `addr_err` is high in the same cycle as `acc_start` when `acc_size` is word (1) or long (2) and `acc_addr[0]` is 1. A byte access (`acc_size` 0) or an even address never raises it.
- R2: On a clock edge with `last_uc` high, `pend_vec` loads the highest-priority pending request: trace (9) over interrupt (24) over illegal next opcode (4). With none of these it loads 0. The new value is visible after that edge.
- R3: `exc_ack` without `last_uc` clears `pend_vec` to 0. When both are high, `last_uc` wins.
- R4: A fault is detected on the edge where `addr_err` or `bus_fault` is high. `fault_start` then pulses for exactly one cycle, raised by the edge `CAP_DLY` clocks (default 2) after the detecting edge.
- R5: The status word `ssw` has bit 4 = read/write of the faulting access (1 = read), bit 3 = the in/not-instruction flag and bits 2..0 = function code. Every other bit is 0. It holds its value until the next capture.
- R6: Bit 3 of `ssw` is 1 exactly when `pend_vec` is nonzero on the capture edge. A fault in the last microcycle with an illegal next opcode gives 1. A fault with an ordinary next opcode and nothing pending gives 0. A fault detected before a `last_uc` load that lands ahead of the capture edge also gives 1.
- R7: A fault in the last microcycle while a trace or an interrupt is requested gives bit 3 = 1.
- R8: Detecting or capturing a bus or address error leaves `pend_vec` unchanged.
- R9: `fault_vec` is 3 for an address error and 2 for a bus error. When both occur on the same edge, the address error wins.
- R10: A fault detected after a previous fault and before `frame_done` sets `halt`, which stays high until reset. While halted no `fault_start` pulse occurs. `frame_done` is honoured only after the capture.
- R11: For a bus error, the read/write and function-code fields come from the access starting in the same cycle, or otherwise from the most recently started access.
- R12: After reset, `pend_vec`, `ssw`, `fault_vec`, `fault_start` and `halt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| last_uc | input | 1 | Start of the current instruction's last microcycle |
| next_op_illegal | input | 1 | The next decoded opcode is illegal |
| trace_req | input | 1 | Trace is pending for the current instruction |
| irq_req | input | 1 | Interrupt is pending |
| exc_ack | input | 1 | Group 1 vector consumed; clear the pending vector |
| acc_start | input | 1 | A bus access starts this cycle |
| acc_addr | input | AW | Access address |
| acc_size | input | 2 | 0 byte, 1 word, 2 long |
| acc_read | input | 1 | 1 = read access |
| acc_fc | input | FCW | Access function code |
| bus_fault | input | 1 | External bus error for the current access |
| frame_done | input | 1 | Fault frame stacking finished |
| addr_err | output | 1 | Misaligned access; suppresses the external strobes |
| fault_start | output | 1 | One-cycle pulse: fault processing starts, status word valid |
| fault_vec | output | VW | Vector of the captured fault (2 or 3) |
| pend_vec | output | VW | Pending group 1 vector; 0 means none |
| ssw | output | SSWW | Fault status word |
| halt | output | 1 | Double fault; sticky until reset |

## Verification
Misaligned writes are issued mid-instruction with no pending vector, and in the last microcycle with an ordinary next opcode, an illegal one, a trace and an interrupt. The outcomes separate a status flag taken from the pending vector from one taken from the instruction context. One fault is detected before a last-microcycle load that lands ahead of the capture edge, which shows that the flag is sampled at the capture clock and not at detection. Bus errors are raised one cycle after an even access and together with an odd access, to separate stored attributes from live ones and to show which vector wins. Back-to-back faults check that halt is entered at the capture edge.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  localparam int VEC_NONE    = 0;
  localparam int VEC_BUSERR  = 2;
  localparam int VEC_ADDRERR = 3;
  localparam int VEC_ILLEGAL = 4;
  localparam int VEC_TRACE   = 9;
  localparam int VEC_IRQ     = 24;
endpackage

// File: rtl/exc_vec_latch.sv
module exc_vec_latch
  import exc_pkg::*;
#(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          last_uc,
  input  logic          next_op_illegal,
  input  logic          trace_req,
  input  logic          irq_req,
  input  logic          exc_ack,
  output logic [VW-1:0] pend_vec
);
  logic [VW-1:0] sel_vec;

  // fixed priority among group 1 sources
  always_comb begin
    if (trace_req)            sel_vec = VW'(VEC_TRACE);
    else if (irq_req)         sel_vec = VW'(VEC_IRQ);
    else if (next_op_illegal) sel_vec = VW'(VEC_ILLEGAL);
    else                      sel_vec = VW'(VEC_NONE);
  end

  // loaded early, at the start of the last microcycle; faults never write it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_vec <= '0;
    else if (last_uc) pend_vec <= sel_vec;
    else if (exc_ack) pend_vec <= '0;
  end
endmodule

// File: rtl/exc_access_chk.sv
module exc_access_chk
  import exc_pkg::*;
#(
  parameter int AW  = 24,
  parameter int FCW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_start,
  input  logic [AW-1:0]  acc_addr,
  input  logic [1:0]     acc_size,
  input  logic           acc_read,
  input  logic [FCW-1:0] acc_fc,
  input  logic           bus_fault,
  output logic           addr_err,
  output logic           fault_det,
  output logic           fault_is_addr,
  output logic           fault_read,
  output logic [FCW-1:0] fault_fc
);
  logic           last_read;
  logic [FCW-1:0] last_fc;
  logic           unused_addr_hi;

  assign unused_addr_hi = ^acc_addr[AW-1:1];

  // raised in the access's first cycle so external strobes can be held off
  assign addr_err      = acc_start && (acc_size != SZ_BYTE) && acc_addr[0];
  assign fault_det     = addr_err || bus_fault;
  assign fault_is_addr = addr_err;

  // remember the attributes of the access in flight for a late bus error
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_read <= 1'b0;
      last_fc   <= '0;
    end else if (acc_start) begin
      last_read <= acc_read;
      last_fc   <= acc_fc;
    end
  end

  assign fault_read = acc_start ? acc_read : last_read;
  assign fault_fc   = acc_start ? acc_fc   : last_fc;
endmodule

// File: rtl/exc_fault_seq.sv
module exc_fault_seq
  import exc_pkg::*;
#(
  parameter int FCW     = 3,
  parameter int VW      = 8,
  parameter int SSWW    = 16,
  parameter int CAP_DLY = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fault_det,
  input  logic            fault_is_addr,
  input  logic            fault_read,
  input  logic [FCW-1:0]  fault_fc,
  input  logic [VW-1:0]   pend_vec,
  input  logic            frame_done,
  output logic            fault_start,
  output logic [VW-1:0]   fault_vec,
  output logic [SSWW-1:0] ssw,
  output logic            halt
);
  localparam int CW     = $clog2(CAP_DLY + 1);
  localparam int IN_POS = FCW;
  localparam int RW_POS = FCW + 1;

  logic           busy;
  logic [CW-1:0]  cnt;
  logic           hold_read;
  logic [FCW-1:0] hold_fc;
  logic [VW-1:0]  hold_vec;
  logic           first_fault, second_fault, capture;
  logic [SSWW-1:0] ssw_next;

  assign second_fault = fault_det && busy && !halt;
  assign first_fault  = fault_det && !busy && !halt;
  assign capture      = (cnt == CW'(1)) && !halt && !second_fault;

  // status word assembled from the held access and the live pending vector
  always_comb begin
    ssw_next              = '0;
    ssw_next[FCW-1:0]     = hold_fc;
    ssw_next[IN_POS]      = (pend_vec != '0);
    ssw_next[RW_POS]      = hold_read;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cnt         <= '0;
      halt        <= 1'b0;
      hold_read   <= 1'b0;
      hold_fc     <= '0;
      hold_vec    <= '0;
      fault_start <= 1'b0;
      fault_vec   <= '0;
      ssw         <= '0;
    end else begin
      fault_start <= 1'b0;
      if (second_fault) begin
        halt <= 1'b1;
        cnt  <= '0;
      end else if (first_fault) begin
        busy      <= 1'b1;
        cnt       <= CW'(CAP_DLY);
        hold_read <= fault_read;
        hold_fc   <= fault_fc;
        hold_vec  <= fault_is_addr ? VW'(VEC_ADDRERR) : VW'(VEC_BUSERR);
      end else if (capture) begin
        fault_start <= 1'b1;
        fault_vec   <= hold_vec;
        ssw         <= ssw_next;
        cnt         <= '0;
      end else if (!halt && cnt > CW'(1)) begin
        cnt <= cnt - CW'(1);
      end else if (!halt && frame_done && busy && cnt == '0) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/exc_status_gen.sv
module exc_status_gen
  import exc_pkg::*;
#(
  parameter int AW      = 24,
  parameter int FCW     = 3,
  parameter int VW      = 8,
  parameter int SSWW    = 16,
  parameter int CAP_DLY = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            last_uc,
  input  logic            next_op_illegal,
  input  logic            trace_req,
  input  logic            irq_req,
  input  logic            exc_ack,
  input  logic            acc_start,
  input  logic [AW-1:0]   acc_addr,
  input  logic [1:0]      acc_size,
  input  logic            acc_read,
  input  logic [FCW-1:0]  acc_fc,
  input  logic            bus_fault,
  input  logic            frame_done,
  output logic            addr_err,
  output logic            fault_start,
  output logic [VW-1:0]   fault_vec,
  output logic [VW-1:0]   pend_vec,
  output logic [SSWW-1:0] ssw,
  output logic            halt
);
  logic           fault_det;
  logic           fault_is_addr;
  logic           fault_read;
  logic [FCW-1:0] fault_fc;

  exc_vec_latch #(.VW(VW)) u_latch (
    .clk(clk), .rst_n(rst_n), .last_uc(last_uc),
    .next_op_illegal(next_op_illegal), .trace_req(trace_req),
    .irq_req(irq_req), .exc_ack(exc_ack), .pend_vec(pend_vec)
  );

  exc_access_chk #(.AW(AW), .FCW(FCW)) u_acc (
    .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_read(acc_read), .acc_fc(acc_fc),
    .bus_fault(bus_fault), .addr_err(addr_err), .fault_det(fault_det),
    .fault_is_addr(fault_is_addr), .fault_read(fault_read), .fault_fc(fault_fc)
  );

  exc_fault_seq #(.FCW(FCW), .VW(VW), .SSWW(SSWW), .CAP_DLY(CAP_DLY)) u_seq (
    .clk(clk), .rst_n(rst_n), .fault_det(fault_det),
    .fault_is_addr(fault_is_addr), .fault_read(fault_read),
    .fault_fc(fault_fc), .pend_vec(pend_vec), .frame_done(frame_done),
    .fault_start(fault_start), .fault_vec(fault_vec), .ssw(ssw), .halt(halt)
  );
endmodule

// File: rtl/exc_status_gen_chk.sv
module exc_status_gen_chk
  import exc_pkg::*;
#(
  parameter int VW   = 8,
  parameter int SSWW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            last_uc,
  input logic            trace_req,
  input logic            exc_ack,
  input logic            acc_start,
  input logic [1:0]      acc_size,
  input logic            addr_err,
  input logic            fault_start,
  input logic [VW-1:0]   fault_vec,
  input logic [VW-1:0]   pend_vec,
  input logic [SSWW-1:0] ssw,
  input logic            halt
);
  // R1
  byte_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && acc_size == SZ_BYTE) |-> !addr_err);

  // R2
  trace_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_uc && trace_req) |=> (pend_vec == VW'(VEC_TRACE)));

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!last_uc && !exc_ack) |=> $stable(pend_vec));

  // R4
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_start |=> !fault_start);

  // R5
  ssw_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ssw[SSWW-1:5] == '0);

  // R9
  fault_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_start |-> (fault_vec == VW'(VEC_BUSERR) || fault_vec == VW'(VEC_ADDRERR)));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !fault_start);
endmodule

bind exc_status_gen exc_status_gen_chk #(.VW(VW), .SSWW(SSWW)) u_chk (
  .clk(clk), .rst_n(rst_n), .last_uc(last_uc), .trace_req(trace_req),
  .exc_ack(exc_ack), .acc_start(acc_start), .acc_size(acc_size),
  .addr_err(addr_err), .fault_start(fault_start), .fault_vec(fault_vec),
  .pend_vec(pend_vec), .ssw(ssw), .halt(halt)
);

// File: tb/exc_status_gen_bench.sv
module exc_status_gen_bench;
  localparam int DLY = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        last_uc, next_op_illegal, trace_req, irq_req, exc_ack;
  logic        acc_start, acc_read, bus_fault, frame_done;
  logic [23:0] acc_addr;
  logic [1:0]  acc_size;
  logic [2:0]  acc_fc;
  logic        addr_err, fault_start, halt;
  logic [7:0]  fault_vec, pend_vec;
  logic [15:0] ssw;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  exc_status_gen #(.CAP_DLY(DLY)) u_exc_status_gen (
    .clk(clk), .rst_n(rst_n), .last_uc(last_uc),
    .next_op_illegal(next_op_illegal), .trace_req(trace_req),
    .irq_req(irq_req), .exc_ack(exc_ack), .acc_start(acc_start),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_read(acc_read),
    .acc_fc(acc_fc), .bus_fault(bus_fault), .frame_done(frame_done),
    .addr_err(addr_err), .fault_start(fault_start), .fault_vec(fault_vec),
    .pend_vec(pend_vec), .ssw(ssw), .halt(halt)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int  m_pend, m_cyc, m_exp_ssw, m_exp_vec, m_hold_vec;
  bit  m_busy, m_halt, m_fs, m_hold_rd, m_last_rd;
  int  m_hold_fc, m_last_fc;
  int  cap_q[$];

  function automatic bit exp_ae();
    return acc_start && acc_size != 2'd0 && acc_addr[0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_cyc = 0; m_busy = 0; m_halt = 0; m_fs = 0;
      m_exp_ssw = 0; m_exp_vec = 0; m_last_rd = 0; m_last_fc = 0;
      cap_q.delete();
    end else begin
      bit det, ae, rd;
      int fc;
      m_cyc++;
      ae  = exp_ae();
      det = ae || bus_fault;
      rd  = acc_start ? acc_read : m_last_rd;
      fc  = acc_start ? int'(acc_fc) : m_last_fc;
      m_fs = 0;
      if (!m_halt) begin
        if (det && m_busy) begin
          m_halt = 1;
          cap_q.delete();
        end else if (det) begin
          m_busy = 1;
          cap_q.push_back(m_cyc + DLY);
          m_hold_rd = rd; m_hold_fc = fc;
          m_hold_vec = ae ? 3 : 2;
        end else if (cap_q.size() > 0 && cap_q[0] == m_cyc) begin
          void'(cap_q.pop_front());
          m_fs = 1;
          m_exp_vec = m_hold_vec;
          m_exp_ssw = (int'(m_hold_rd) << 4) | ((m_pend != 0) ? 8 : 0) | m_hold_fc;
        end else if (frame_done && m_busy && cap_q.size() == 0) begin
          m_busy = 0;
        end
      end
      if (last_uc)
        m_pend = trace_req ? 9 : irq_req ? 24 : next_op_illegal ? 4 : 0;
      else if (exc_ack)
        m_pend = 0;
      if (acc_start) begin
        m_last_rd = acc_read;
        m_last_fc = acc_fc;
      end
    end
  end

  // every clock: registered outputs against the reference
  always @(negedge clk) if (rst_n) begin
    chk("R2 pend_vec", pend_vec, m_pend);
    chk("R4 fault_start", fault_start, m_fs);
    chk("R5 ssw", ssw, m_exp_ssw);
    chk("R9 fault_vec", fault_vec, m_exp_vec);
    chk("R10 halt", halt, m_halt);
  end

  task automatic clear_in();
    last_uc = 0; next_op_illegal = 0; trace_req = 0; irq_req = 0;
    exc_ack = 0; acc_start = 0; bus_fault = 0; frame_done = 0;
  endtask

  // inputs are set before the call; addr_err is combinational (R1)
  task automatic tick();
    #1 chk("R1 addr_err", addr_err, exp_ae());
    @(negedge clk);
    clear_in();
  endtask

  task automatic access(logic [23:0] a, logic [1:0] sz, logic rd, logic [2:0] fc);
    acc_start = 1; acc_addr = a; acc_size = sz; acc_read = rd; acc_fc = fc;
  endtask

  task automatic wait_cap();
    repeat (DLY) tick();
  endtask

  task automatic finish_frame();
    frame_done = 1; exc_ack = 1; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    acc_addr = 0; acc_size = 0; acc_read = 0; acc_fc = 0;
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 pend_vec", pend_vec, 0);
    chk("R12 ssw", ssw, 0);
    chk("R12 fault_vec", fault_vec, 0);
    chk("R12 fault_start", fault_start, 0);
    chk("R12 halt", halt, 0);
    rst_n = 1;
    tick();

    // R1: aligned and byte accesses never fault
    access(24'h001001, 2'd0, 1, 3'd1); tick();
    access(24'h002000, 2'd1, 1, 3'd2); tick();
    access(24'h002004, 2'd2, 0, 3'd1); tick();
    tick();
    chk("R1 no fault from aligned/byte", fault_start, 0);

    // R6: fault mid-instruction, nothing pending -> flag 0
    access(24'h003003, 2'd1, 0, 3'd1); tick();
    wait_cap();
    chk("R4 pulse at capture", fault_start, 1);
    chk("R6 mid-instruction ssw", ssw, 'h01);
    chk("R9 address vector", fault_vec, 3);
    finish_frame();

    // R6: last microcycle, illegal next opcode -> flag 1
    last_uc = 1; next_op_illegal = 1; access(24'h004001, 2'd1, 0, 3'd5); tick();
    wait_cap();
    chk("R6 illegal next ssw", ssw, 'h0D);
    chk("R8 latch untouched by fault", pend_vec, 4);
    finish_frame();

    // R6: last microcycle, ordinary next opcode -> flag 0
    last_uc = 1; access(24'h004003, 2'd1, 0, 3'd1); tick();
    wait_cap();
    chk("R6 ordinary next ssw", ssw, 'h01);
    finish_frame();

    // R7: trace pending, long read
    last_uc = 1; trace_req = 1; access(24'h005001, 2'd2, 1, 3'd6); tick();
    wait_cap();
    chk("R7 trace ssw", ssw, 'h1E);
    finish_frame();

    // R7: interrupt pending
    last_uc = 1; irq_req = 1; access(24'h005003, 2'd1, 0, 3'd2); tick();
    wait_cap();
    chk("R7 interrupt ssw", ssw, 'h0A);
    chk("R2 interrupt vector", pend_vec, 24);
    finish_frame();

    // R6: load lands between detection and capture
    access(24'h006001, 2'd1, 0, 3'd1); tick();
    last_uc = 1; next_op_illegal = 1; tick();
    tick();
    chk("R6 sampled at capture clock", ssw, 'h09);
    finish_frame();

    // R2 priority and R3 clearing
    last_uc = 1; trace_req = 1; irq_req = 1; next_op_illegal = 1; tick();
    chk("R2 trace first", pend_vec, 9);
    last_uc = 1; irq_req = 1; next_op_illegal = 1; tick();
    chk("R2 interrupt over illegal", pend_vec, 24);
    last_uc = 1; next_op_illegal = 1; exc_ack = 1; tick();
    chk("R3 load wins over ack", pend_vec, 4);
    exc_ack = 1; tick();
    chk("R3 ack clears", pend_vec, 0);

    // R8: pending vector held across a fault
    last_uc = 1; next_op_illegal = 1; tick();
    access(24'h007001, 2'd1, 1, 3'd5); tick();
    wait_cap();
    chk("R8 pend held", pend_vec, 4);
    chk("R6 flag from held vector", ssw, 'h1D);
    finish_frame();

    // R11 / R9: late bus error uses stored attributes
    access(24'h008000, 2'd1, 1, 3'd5); tick();
    bus_fault = 1; tick();
    wait_cap();
    chk("R9 bus vector", fault_vec, 2);
    chk("R11 stored attributes", ssw, 'h15);
    finish_frame();

    // R9: address error wins over bus error
    access(24'h008001, 2'd1, 1, 3'd2); bus_fault = 1; tick();
    wait_cap();
    chk("R9 address wins", fault_vec, 3);
    finish_frame();

    // R10: second fault before the frame is done
    access(24'h009001, 2'd1, 0, 3'd1); tick();
    tick();
    access(24'h009003, 2'd1, 0, 3'd1); tick();
    chk("R10 halt set", halt, 1);
    chk("R10 no capture when halting", fault_start, 0);
    access(24'h009005, 2'd1, 0, 3'd1); frame_done = 1; tick();
    repeat (4) tick();
    chk("R10 halt sticky", halt, 1);
    chk("R10 no pulse while halted", fault_start, 0);

    rst_n = 0;
    @(negedge clk);
    chk("R12 halt cleared by reset", halt, 0);
    rst_n = 1;
    tick();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule